// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives a host controller read and write access to a file of 32 byte-wide configuration registers. Each access opens with chip select going low and an instruction byte, sent on the first eight rising edges of the serial clock. The instruction byte holds a direction flag, a two-bit burst code for one to four bytes, and a five-bit start address. The data bytes follow on the same clock. The register file runs on the serial clock itself, and its full contents appear on a flat parallel output for the logic around it.

Register 0 is the port's own control register. Bit 6 of that register selects least-significant-bit-first transfer order, and bit 7 moves read data from the shared data pin to a dedicated output pin. Read bits are launched on the falling clock edge, so the host can sample each one on the following rising edge. Raising chip select at any point returns the port to the instruction phase and drops any byte that is only partly shifted in.

Top module: `spi_cfg_slave`

## Requirements
- R1: The first eight rising edges of SCLK after CSB falls shift in the instruction byte. In that byte, bit 7 set means read, bits 6:5 hold the burst code and bits 4:0 hold the start address. No register is written during the instruction phase.
- R2: Burst code 00, 01, 10 or 11 selects 1, 2, 3 or 4 data bytes. Any byte sent after the burst is complete is ignored and writes nothing.
- R3: A write byte is stored in its register on the rising edge that shifts in its eighth bit, before CSB returns high.
- R4: When CSB rises partway through a byte, that byte is discarded and no register changes. The next low period of CSB starts again with an instruction byte.
- R5: After reset the order is MSB first, and the address decrements by one (modulo 32) after each data byte.
- R6: Writing 1 to bit 6 of register 0 selects LSB-first order for both instruction and data bytes, and the address then increments by one (modulo 32) after each data byte.
- R7: In a read, each bit is launched on a falling SCLK edge in the selected order and holds until the next falling edge. The first bit is launched on the falling edge that follows the eighth instruction bit.
- R8: In 3-wire mode (bit 7 of register 0 clear), sdio_oe is high only during the data bytes of a read burst, read data appears on sdio_o, and sdo stays low.
- R9: In 4-wire mode (bit 7 of register 0 set), read data appears on sdo, sdo is low outside read data bytes, and sdio_oe stays low.
- R10: While rst_n is low, every register is 0, sdio_oe is low and sdo is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| sclk | input | 1 | Serial clock; it also clocks the registers |
| csb | input | 1 | Active-low chip select that frames each transaction |
| sdio_i | input | 1 | Serial data in |
| sdio_o | output | 1 | Serial read data for the shared pin in 3-wire mode |
| sdio_oe | output | 1 | Output enable for the shared data pin |
| sdo | output | 1 | Serial read data in 4-wire mode |
| reg_q | output | 256 | Contents of all 32 registers; register n is at bits 8n+7:8n |

## Verification
Any fault in the bit counter or the phase state changes which edge completes a byte. Because reg_q is compared with the model right after every data byte, such a fault shows up within one byte time. A wrong address step or burst count writes a neighbouring register or leaves one unwritten, and the next comparison of the whole register file exposes it. Faults in the read path (bit index, launch edge or enable) show in the first byte of the next read. The bench checks every read bit against its model, and it checks the enable and the spare pin at every bit time.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 5;
  localparam int NREG         = 1 << ADDR_W;
  localparam int CNT_W        = $clog2(BYTE_W);
  localparam int LEN_W        = 3;
  localparam int CTRL_ADDR    = 0;
  localparam int CTRL_LSB_BIT = 6;
  localparam int CTRL_SDO_BIT = 7;

  typedef struct packed {
    logic              rd;
    logic [1:0]        len;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  // Whole byte formed from the seven held bits plus the bit on the pin now.
  function automatic logic [BYTE_W-1:0] join_byte(input logic lsb,
                                                  input logic [BYTE_W-2:0] held,
                                                  input logic b);
    return lsb ? {b, held} : {held, b};
  endfunction

  // Held bits after this edge, taken from the joined byte.
  function automatic logic [BYTE_W-2:0] keep_bits(input logic lsb,
                                                  input logic [BYTE_W-1:0] joined);
    return lsb ? joined[BYTE_W-1:1] : joined[BYTE_W-2:0];
  endfunction

  function automatic logic [LEN_W-1:0] burst_bytes(input logic [1:0] code);
    return LEN_W'(code) + LEN_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic lsb,
                                                  input logic [ADDR_W-1:0] a);
    return lsb ? a + ADDR_W'(1) : a - ADDR_W'(1);
  endfunction

  // Bit of the read byte that goes out at bit slot 'slot'.
  function automatic logic [CNT_W-1:0] out_index(input logic lsb,
                                                 input logic [CNT_W-1:0] slot);
    return lsb ? slot : CNT_W'(BYTE_W - 1) - slot;
  endfunction

endpackage

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
(
  input  logic              sclk,
  input  logic              port_clr,
  input  logic              sdio_i,
  input  logic              lsb,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);

  logic [BYTE_W-2:0] held;

  assign byte_val  = join_byte(lsb, held, sdio_i);
  assign byte_done = (bit_cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge sclk or posedge port_clr) begin
    if (port_clr) begin
      bit_cnt <= '0;
      held    <= '0;
    end else begin
      bit_cnt <= bit_cnt + CNT_W'(1);
      held    <= keep_bits(lsb, byte_val);
    end
  end

endmodule

// File: rtl/spi_cfg_sequencer.sv
module spi_cfg_sequencer
  import spi_cfg_pkg::*;
(
  input  logic              sclk,
  input  logic              port_clr,
  input  logic              lsb,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              instr_done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_active,
  output logic [ADDR_W-1:0] cur_addr
);

  logic             in_data;
  logic             is_rd;
  logic [LEN_W-1:0] left;
  instr_t           ins;

  assign ins        = instr_t'(byte_val);
  assign instr_done = byte_done && !in_data;
  assign wr_en      = byte_done && in_data && !is_rd && (left != '0);
  assign wr_addr    = cur_addr;
  assign wr_data    = byte_val;
  assign rd_active  = in_data && is_rd && (left != '0);

  always_ff @(posedge sclk or posedge port_clr) begin
    if (port_clr) begin
      in_data  <= 1'b0;
      is_rd    <= 1'b0;
      left     <= '0;
      cur_addr <= '0;
    end else if (instr_done) begin
      in_data  <= 1'b1;
      is_rd    <= ins.rd;
      left     <= burst_bytes(ins.len);
      cur_addr <= ins.addr;
    end else if (byte_done && (left != '0)) begin
      left     <= left - LEN_W'(1);
      cur_addr <= step_addr(lsb, cur_addr);
    end
  end

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
(
  input  logic                   sclk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [BYTE_W-1:0]      rd_byte,
  output logic                   lsb,
  output logic                   sdo_mode,
  output logic [NREG*BYTE_W-1:0] reg_q
);

  logic [BYTE_W-1:0] regs [NREG];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign reg_q[g*BYTE_W +: BYTE_W] = regs[g];
  end

  assign rd_byte  = regs[rd_addr];
  assign lsb      = regs[CTRL_ADDR][CTRL_LSB_BIT];
  assign sdo_mode = regs[CTRL_ADDR][CTRL_SDO_BIT];

endmodule

// File: rtl/spi_cfg_readout.sv
module spi_cfg_readout
  import spi_cfg_pkg::*;
(
  input  logic              sclk,
  input  logic              port_clr,
  input  logic              lsb,
  input  logic              sdo_mode,
  input  logic              rd_active,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo
);

  logic out_q;

  always_ff @(negedge sclk or posedge port_clr) begin
    if (port_clr) out_q <= 1'b0;
    else          out_q <= rd_active ? rd_byte[out_index(lsb, bit_cnt)] : 1'b0;
  end

  assign sdio_o  = sdo_mode ? 1'b0 : out_q;
  assign sdo     = sdo_mode ? out_q : 1'b0;
  assign sdio_oe = rd_active && !sdo_mode;

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
(
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   csb,
  input  logic                   sdio_i,
  output logic                   sdio_o,
  output logic                   sdio_oe,
  output logic                   sdo,
  output logic [NREG*BYTE_W-1:0] reg_q
);

  logic              port_clr;
  logic              lsb;
  logic              sdo_mode;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              instr_done;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_active;
  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] rd_byte;

  assign port_clr = csb || !rst_n;

  spi_cfg_shifter u_shift (
    .sclk(sclk), .port_clr(port_clr), .sdio_i(sdio_i), .lsb(lsb),
    .bit_cnt(bit_cnt), .byte_done(byte_done), .byte_val(byte_val)
  );

  spi_cfg_sequencer u_seq (
    .sclk(sclk), .port_clr(port_clr), .lsb(lsb),
    .byte_done(byte_done), .byte_val(byte_val), .instr_done(instr_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_active(rd_active), .cur_addr(cur_addr)
  );

  spi_cfg_regfile u_regs (
    .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(cur_addr), .rd_byte(rd_byte),
    .lsb(lsb), .sdo_mode(sdo_mode), .reg_q(reg_q)
  );

  spi_cfg_readout u_out (
    .sclk(sclk), .port_clr(port_clr), .lsb(lsb), .sdo_mode(sdo_mode),
    .rd_active(rd_active), .bit_cnt(bit_cnt), .rd_byte(rd_byte),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo)
  );

endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker
  import spi_cfg_pkg::*;
(
  input logic                   sclk,
  input logic                   rst_n,
  input logic                   port_clr,
  input logic                   instr_done,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [BYTE_W-1:0]      wr_data,
  input logic                   rd_active,
  input logic                   sdo_mode,
  input logic                   sdio_oe,
  input logic                   sdo,
  input logic [NREG*BYTE_W-1:0] reg_q
);

  logic [ADDR_W-1:0] last_addr;
  logic [BYTE_W-1:0] last_data;
  logic [3:0]        wr_cnt;

  always_ff @(posedge sclk) begin
    last_addr <= wr_addr;
    last_data <= wr_data;
  end

  always_ff @(posedge sclk or posedge port_clr) begin
    if (port_clr)   wr_cnt <= '0;
    else if (wr_en) wr_cnt <= wr_cnt + 4'd1;
  end

  AST_WRITE_COMMIT: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |=> (reg_q[last_addr*BYTE_W +: BYTE_W] == last_data)); // R3

  AST_NO_INSTR_WRITE: assert property (@(posedge sclk) disable iff (port_clr)
    instr_done |-> !wr_en); // R1

  AST_BURST_LIMIT: assert property (@(posedge sclk) disable iff (port_clr)
    wr_cnt <= 4'd4); // R2

  AST_READ_NO_WRITE: assert property (@(posedge sclk) disable iff (port_clr)
    rd_active |-> !wr_en); // R7

  AST_SDO_QUIET_3W: assert property (@(negedge sclk) disable iff (port_clr)
    !sdo_mode |=> !sdo); // R8

  AST_OE_LOW_4W: assert property (@(negedge sclk) disable iff (port_clr)
    sdo_mode |-> !sdio_oe); // R9

endmodule

bind spi_cfg_slave spi_cfg_checker u_chk (
  .sclk(sclk), .rst_n(rst_n), .port_clr(port_clr), .instr_done(instr_done),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_active(rd_active),
  .sdo_mode(sdo_mode), .sdio_oe(sdio_oe), .sdo(sdo), .reg_q(reg_q)
);

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;

  logic         sclk = 1'b0;
  logic         csb = 1'b1;
  logic         rst_n = 1'b0;
  logic         sdio_i = 1'b0;
  logic         sdio_o, sdio_oe, sdo;
  logic [255:0] reg_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [32];

  spi_cfg_slave dut (
    .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .reg_q(reg_q)
  );

  always #2.5 sclk = ~sclk;

  function automatic logic [255:0] model_flat();
    logic [255:0] f;
    for (int i = 0; i < 32; i++) f[i*8 +: 8] = mem[i];
    return f;
  endfunction

  function automatic bit m_lsb(); return mem[0][6]; endfunction
  function automatic bit m_4w();  return mem[0][7]; endfunction

  function automatic logic [4:0] next_a(input bit lsb, input logic [4:0] a);
    return lsb ? 5'(a + 1) : 5'(a - 1);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shift one byte starting at a falling edge; ends at the falling edge
  // after the byte's last rising edge.
  task automatic shift_byte(input logic [7:0] b, input bit exp_rd, input int nbits,
                            output logic [7:0] got, output bit bad);
    bit lsb = m_lsb();
    bit w4  = m_4w();
    got = '0;
    bad = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      int idx = lsb ? k : 7 - k;
      sdio_i = b[idx];
      #2;
      got[idx] = w4 ? sdo : sdio_o;
      if (sdio_oe !== (exp_rd && !w4)) bad = 1'b1;
      if (!w4 && sdo !== 1'b0) bad = 1'b1;
      if (w4 && !exp_rd && sdo !== 1'b0) bad = 1'b1;
      @(negedge sclk);
    end
  endtask

  task automatic xfer(input bit rd, input int len, input logic [4:0] a0,
                      input int nsend, input logic [31:0] d);
    logic [7:0] instr, got;
    logic [4:0] a;
    bit bad, lsb;
    string pin_req;
    instr = {rd, 2'(len - 1), a0};
    @(negedge sclk);
    csb = 1'b0;
    pin_req = m_4w() ? "R9" : "R8";
    shift_byte(instr, 1'b0, 8, got, bad);
    check(!bad, "R1 instruction-phase pins", {255'd0, bad}, 256'd0);
    a = a0;
    for (int i = 0; i < nsend; i++) begin
      bit exp_rd = rd && (i < len);
      lsb = m_lsb();
      pin_req = m_4w() ? "R9" : "R8";
      shift_byte(d[i*8 +: 8], exp_rd, 8, got, bad);
      check(!bad, pin_req, {255'd0, bad}, 256'd0);
      if (exp_rd) check(got === mem[a], "R7 read data", {248'd0, got}, {248'd0, mem[a]});
      if (!rd && i < len) mem[a] = d[i*8 +: 8];
      if (i < len) a = next_a(lsb, a);
      // Written bytes must already show before CSB rises (R3); the order tag names the step rule
      check(reg_q === model_flat(), i >= len ? "R2 extra byte" : (lsb ? "R3 R6" : "R3 R5"),
            reg_q, model_flat());
    end
    csb = 1'b1;
    @(negedge sclk);
  endtask

  task automatic abort_xfer(input logic [4:0] a0, input int instr_bits, input int data_bits);
    logic [7:0] got;
    bit bad;
    @(negedge sclk);
    csb = 1'b0;
    shift_byte({1'b0, 2'b00, a0}, 1'b0, instr_bits, got, bad);
    if (instr_bits == 8) shift_byte(8'hFF, 1'b0, data_bits, got, bad);
    csb = 1'b1;
    @(negedge sclk);
    check(reg_q === model_flat(), "R4 abort keeps registers", reg_q, model_flat());
  endtask

  task automatic rand_ops(input int n);
    for (int t = 0; t < n; t++) begin
      bit rd = 1'($urandom_range(0, 1));
      int len = $urandom_range(1, 4);
      logic [4:0] a0 = rd ? 5'($urandom_range(0, 31)) : 5'($urandom_range(4, 27));
      int nsend = len + (($urandom_range(0, 4) == 0) ? 1 : 0);
      xfer(rd, len, a0, nsend, $urandom);
    end
  endtask

  initial begin
    repeat (100000) @(posedge sclk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    #12;
    check(reg_q === 256'd0, "R10 registers in reset", reg_q, 256'd0);
    check(sdio_oe === 1'b0 && sdo === 1'b0, "R10 pins in reset",
          {254'd0, sdio_oe, sdo}, 256'd0);
    @(negedge sclk);
    rst_n = 1'b1;

    // Single write then read back, MSB first (R5)
    xfer(1'b0, 1, 5'd5, 1, 32'h000000A5);
    xfer(1'b1, 1, 5'd5, 1, 32'h0);
    // Four-byte burst with decrementing addresses (R5, R2)
    xfer(1'b0, 4, 5'd20, 4, 32'h44332211);
    xfer(1'b1, 4, 5'd20, 4, 32'h0);
    // Burst overrun: bytes past the count are ignored (R2)
    xfer(1'b0, 1, 5'd9, 3, 32'h00CCBB5A);
    xfer(1'b1, 2, 5'd9, 3, 32'h0);
    // Aborts inside the instruction and inside a data byte (R4)
    abort_xfer(5'd12, 3, 0);
    abort_xfer(5'd12, 8, 5);
    abort_xfer(5'd12, 8, 7);
    xfer(1'b0, 1, 5'd12, 1, 32'h0000003C);
    // Address wrap below zero skipped for writes; read wraps 1,0,31
    xfer(1'b1, 3, 5'd1, 3, 32'h0);
    rand_ops(30);

    // LSB-first order, incrementing addresses (R6)
    xfer(1'b0, 1, 5'd0, 1, 32'h00000040);
    xfer(1'b0, 3, 5'd10, 3, 32'h00F00DAB);
    xfer(1'b1, 3, 5'd10, 3, 32'h0);
    xfer(1'b1, 2, 5'd31, 2, 32'h0);
    rand_ops(30);

    // 4-wire with LSB first, then 4-wire MSB first (R9)
    xfer(1'b0, 1, 5'd0, 1, 32'h000000C0);
    xfer(1'b1, 4, 5'd4, 5, 32'h0);
    rand_ops(15);
    xfer(1'b0, 1, 5'd0, 1, 32'h00000080);
    xfer(1'b1, 2, 5'd20, 2, 32'h0);
    rand_ops(15);
    xfer(1'b0, 1, 5'd0, 1, 32'h00000000);
    rand_ops(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule